// File: doc/BRIEF.md
# DRAM Leadoff Timing Sequencer

This block counts the clocks of one DRAM access, from the accepted start strobe to the first data. It asserts a one-cycle CAS strobe at the point where the address has been set up, and a one-cycle done strobe when the leadoff ends. The leadoff length depends on the access direction, on the state of the open page, and on a 2-bit speed field. Only the two odd codes of the speed field shorten an access, and only one that has to open a row.

The speed field shortens a leadoff by moving the CAS point one clock earlier, which takes the clock out of the address-setup interval. Page-hit accesses have a fixed latency whatever the field holds. The direction, the page status and the speed field are all captured with the start strobe and stay fixed until the access ends. A start strobe that arrives during an access is dropped.

Top module: `dram_leadoff_seq`

## Requirements
- R1: The page status input uses these encodings: 00 page hit, 01 page miss, 10 row miss, 11 also row miss. Speed codes 00 and 10 are slow. Speed codes 01 and 11 are fast, one clock shorter.
- R2: A row-miss read has an 11-clock leadoff with a slow code and a 10-clock leadoff with a fast code. Page status 11 gives the same timing.
- R3: A row-miss write has a 7-clock leadoff with a slow code and a 6-clock leadoff with a fast code.
- R4: A page miss takes 3 clocks less than the row miss of the same direction and speed: read 8 or 7, write 4 or 3.
- R5: A page-hit read takes 7 clocks and a page-hit write takes 3 clocks, for every speed code.
- R6: Take the cycle in which the start is accepted as cycle 0. cas_o is high for exactly one cycle, at cycle L-3 for a read and at cycle L-1 for a write, where L is the leadoff.
- R7: done_o is high for exactly one cycle, at cycle L. busy_o is high from cycle 1 through cycle L and low in cycle L+1.
- R8: A start strobe is ignored while busy_o is high. No access is queued.
- R9: Changes to the direction, page status and speed inputs during an access do not alter its timing.
- R10: While rst_ni is low, busy_o, cas_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access start strobe |
| is_write_i | input | 1 | 1 selects a write, 0 selects a read |
| page_st_i | input | 2 | Page status: 00 hit, 01 page miss, 1x row miss |
| speed_i | input | 2 | Leadoff speed field |
| cas_o | output | 1 | One-cycle CAS assertion strobe |
| done_o | output | 1 | One-cycle leadoff-complete strobe |
| busy_o | output | 1 | An access is in progress |

## Verification
The hardest case to reach is an access whose inputs change while it is in progress. In that case a second start strobe arrives together with a new direction, page status and speed, and the block must keep the timing it captured earlier. The stimulus starts a long row-miss read. It then raises start again during cycle 2 with every control input flipped to describe a short fast page-hit write. The bench checks that the CAS point and the done point match the original access. It also checks that busy_o stays low for a cycle after the access ends, which shows that no second access was queued.

// File: rtl/dram_leadoff_pkg.sv
package dram_leadoff_pkg;
  typedef enum logic [1:0] {
    PG_HIT   = 2'b00,
    PG_MISS  = 2'b01,
    PG_ROW   = 2'b10,
    PG_ROW_X = 2'b11
  } page_st_e;

  localparam int unsigned LEAD_W = 4;
endpackage

// File: rtl/leadoff_decode.sv
module leadoff_decode
  import dram_leadoff_pkg::*;
#(
  parameter int unsigned CNT_W   = LEAD_W,
  parameter int unsigned RM_RD   = 11,
  parameter int unsigned RM_WR   = 7,
  parameter int unsigned PM_SAVE = 3,
  parameter int unsigned PH_RD   = 7,
  parameter int unsigned PH_WR   = 3,
  parameter int unsigned RD_TAIL = 3,
  parameter int unsigned WR_TAIL = 1
) (
  input  logic             is_write_i,
  input  page_st_e         page_st_i,
  input  logic [1:0]       speed_i,
  output logic [CNT_W-1:0] lead_o,
  output logic [CNT_W-1:0] cas_pt_o
);
  localparam logic [CNT_W-1:0] RmRd = CNT_W'(RM_RD);
  localparam logic [CNT_W-1:0] RmWr = CNT_W'(RM_WR);
  localparam logic [CNT_W-1:0] PmSv = CNT_W'(PM_SAVE);
  localparam logic [CNT_W-1:0] PhRd = CNT_W'(PH_RD);
  localparam logic [CNT_W-1:0] PhWr = CNT_W'(PH_WR);
  localparam logic [CNT_W-1:0] RdTl = CNT_W'(RD_TAIL);
  localparam logic [CNT_W-1:0] WrTl = CNT_W'(WR_TAIL);

  logic [CNT_W-1:0] fast_dec;
  logic [CNT_W-1:0] row_lead;

  // odd codes trim one clock of address setup before CAS
  assign fast_dec = {{(CNT_W-1){1'b0}}, speed_i[0]};
  assign row_lead = (is_write_i ? RmWr : RmRd) - fast_dec;

  always_comb begin
    unique case (page_st_i)
      PG_HIT:  lead_o = is_write_i ? PhWr : PhRd;
      PG_MISS: lead_o = row_lead - PmSv;
      default: lead_o = row_lead;
    endcase
  end

  assign cas_pt_o = lead_o - (is_write_i ? WrTl : RdTl);
endmodule

// File: rtl/leadoff_counter.sv
module leadoff_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] lead_i,
  input  logic [CNT_W-1:0] cas_pt_i,
  output logic             cas_o,
  output logic             done_o,
  output logic             busy_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, lead_q, cas_q;
  logic             accept;

  assign accept = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lead_q <= '0;
      cas_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
      lead_q <= lead_i;
      cas_q  <= cas_pt_i;
    end else if (busy_q) begin
      if (cnt_q == lead_q) busy_q <= 1'b0;
      else                 cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign done_o = busy_q & (cnt_q == lead_q);
  assign cas_o  = busy_q & (cnt_q == cas_q);
  assign busy_o = busy_q;

  a_r7_busy_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r6_cas_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_o |-> busy_o && !done_o);
  a_r6_cas_before_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cas_q != '0) && (cas_q < lead_q));
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_o |=> busy_q && (cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r9_hold_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_o |=> $stable(lead_q) && $stable(cas_q));
  a_r7_start_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o && (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/dram_leadoff_seq.sv
module dram_leadoff_seq
  import dram_leadoff_pkg::*;
#(
  parameter int unsigned CNT_W = LEAD_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       is_write_i,
  input  logic [1:0] page_st_i,
  input  logic [1:0] speed_i,
  output logic       cas_o,
  output logic       done_o,
  output logic       busy_o
);
  logic [CNT_W-1:0] lead_w, cas_pt_w;

  leadoff_decode #(.CNT_W(CNT_W)) i_decode (
    .is_write_i (is_write_i),
    .page_st_i  (page_st_e'(page_st_i)),
    .speed_i    (speed_i),
    .lead_o     (lead_w),
    .cas_pt_o   (cas_pt_w)
  );

  leadoff_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .lead_i   (lead_w),
    .cas_pt_i (cas_pt_w),
    .cas_o    (cas_o),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );

  a_r10_quiet_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !cas_o && !done_o);
endmodule

// File: tb/test_dram_leadoff_seq.sv
module test_dram_leadoff_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0;
  logic [1:0] pg = 2'b00, spd = 2'b00;
  logic cas, done, busy;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dram_leadoff_seq i_dram_leadoff_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .is_write_i(wr),
    .page_st_i(pg), .speed_i(spd), .cas_o(cas), .done_o(done), .busy_o(busy)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // disturb: restart and flip all controls in cycle 2 (R8, R9)
  task automatic access(string req, bit w, bit [1:0] p, bit [1:0] s,
                        int lead, int casp, bit disturb);
    int cas_cyc = -1, done_cyc = -1, cas_n = 0, done_n = 0, busy_bad = 0;
    @(negedge clk);
    start = 1'b1; wr = w; pg = p; spd = s;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= lead + 1; k++) begin
      if (disturb && k == 2) begin
        start = 1'b1; wr = ~w; pg = 2'b00; spd = ~s;
      end
      if (disturb && k == 3) start = 1'b0;
      if (cas)  begin cas_n++;  cas_cyc = k;  end
      if (done) begin done_n++; done_cyc = k; end
      if (k <= lead && !busy) busy_bad++;
      if (k == lead + 1 && busy) busy_bad++;
      @(negedge clk);
    end
    check({req, " R6 cas cycle"}, cas_cyc, casp);
    check({req, " R6 cas count"}, cas_n, 1);
    check({req, " R7 done cycle"}, done_cyc, lead);
    check({req, " R7 done count"}, done_n, 1);
    check({req, " R7 busy window"}, busy_bad, 0);
    check({req, " R8 idle after"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    check("R10 busy in reset", int'(busy), 0);
    check("R10 cas in reset", int'(cas), 0);
    check("R10 done in reset", int'(done), 0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", int'(busy), 0);
  endtask

  task automatic t_row();
    access("R2 rd s00", 1'b0, 2'b10, 2'b00, 11, 8, 1'b0);
    access("R2 rd s01", 1'b0, 2'b10, 2'b01, 10, 7, 1'b0);
    access("R2 rd s10", 1'b0, 2'b10, 2'b10, 11, 8, 1'b0);
    access("R2 rd s11", 1'b0, 2'b10, 2'b11, 10, 7, 1'b0);
    access("R1 R2 pg11", 1'b0, 2'b11, 2'b00, 11, 8, 1'b0);
    access("R3 wr s00", 1'b1, 2'b10, 2'b00, 7, 6, 1'b0);
    access("R3 wr s11", 1'b1, 2'b10, 2'b11, 6, 5, 1'b0);
  endtask

  task automatic t_page_miss();
    access("R4 rd s00", 1'b0, 2'b01, 2'b00, 8, 5, 1'b0);
    access("R4 rd s01", 1'b0, 2'b01, 2'b01, 7, 4, 1'b0);
    access("R4 wr s10", 1'b1, 2'b01, 2'b10, 4, 3, 1'b0);
    access("R4 wr s01", 1'b1, 2'b01, 2'b01, 3, 2, 1'b0);
  endtask

  task automatic t_page_hit();
    access("R5 rd s00", 1'b0, 2'b00, 2'b00, 7, 4, 1'b0);
    access("R5 rd s11", 1'b0, 2'b00, 2'b11, 7, 4, 1'b0);
    access("R5 wr s01", 1'b1, 2'b00, 2'b01, 3, 2, 1'b0);
    access("R5 wr s10", 1'b1, 2'b00, 2'b10, 3, 2, 1'b0);
  endtask

  task automatic t_disturb();
    access("R8 R9 row rd", 1'b0, 2'b10, 2'b00, 11, 8, 1'b1);
    access("R8 R9 pm wr", 1'b1, 2'b01, 2'b01, 3, 2, 1'b1);
  endtask

  initial begin
    t_reset();
    t_row();
    t_page_miss();
    t_page_hit();
    t_disturb();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule